// File: doc/BRIEF.md
# USB Host Interrupt Status Register

This block holds the interrupt status flags of a USB 2.0 host controller. It turns controller-side events into four sticky flags that software reads and clears: a frame list wrap, a port event on a port this controller owns, a transaction that ended in error, and a transaction that should raise a completion interrupt. The events come from three sources. One is the top bit of the frame index, bit 13 of the frame number counter. The others are per-port change and resume-transition levels, each qualified by a per-port owner bit, and a per-cycle transaction completion report with error, interrupt-on-complete and short-packet qualifiers.

Software reaches the block through a one-bit-address register bus. Address 0 is the status register and address 1 is an interrupt enable register. A status bit is cleared only by writing a one to it. The interrupt output stays high while any enabled status bit is set.

Top module: `usb_irq_status`

## Requirements
- R1: Out of reset the status register and the enable register read 0 and `irq_o` is low.
- R2: A write to address 0 clears each status bit whose data bit is 1 and leaves each bit whose data bit is 0 unchanged.
- R3: Status bit 3 (frame wrap) sets on the clock edge at which `frnum_wrap_i` differs from its value at the previous edge, for both rising and falling transitions.
- R4: Status bit 2 (port event) sets on the edge at which a 0-to-1 transition is seen on `port_chg_i[p]` or `port_resume_i[p]` for a port p whose `port_owner_i[p]` is 0. A level held high does not set it again.
- R5: A transition on a port whose `port_owner_i` bit is 1 does not set status bit 2.
- R6: A valid completion with `cmpl_err_i` set sets status bit 1 (error). Without `cmpl_ioc_i` or `cmpl_short_i` it leaves bit 0 unchanged.
- R7: A valid completion with `cmpl_ioc_i` or `cmpl_short_i` set sets status bit 0 (completion).
- R8: A valid completion with both `cmpl_err_i` and `cmpl_ioc_i` set sets status bits 1 and 0 on the same edge.
- R9: When a hardware set and a software write-one-to-clear hit the same bit on the same edge, the bit ends up set.
- R10: Address 1 is a read/write enable register, bit i enabling status bit i. `irq_o` is high exactly while some status bit and its enable bit are both 1, and stays high until software clears those bits or disables them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frnum_wrap_i | input | 1 | Bit 13 of the frame number counter |
| port_chg_i | input | NUM_PORTS | Per-port change bits |
| port_resume_i | input | NUM_PORTS | Per-port force-resume bits |
| port_owner_i | input | NUM_PORTS | 1 = port handed to companion controller |
| cmpl_vld_i | input | 1 | Transaction completion report valid |
| cmpl_err_i | input | 1 | Completion ended in error |
| cmpl_ioc_i | input | 1 | Descriptor had interrupt-on-complete |
| cmpl_short_i | input | 1 | Short packet received |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 1 | Register select: 0 status, 1 enable |
| bus_wdata_i | input | 4 | Write data |
| bus_rdata_o | output | 4 | Read data of the selected register |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench toggles the frame wrap bit in both directions and changes only the low frame bits. A detector that saw one edge direction would miss half of the wraps, and one that watched the whole counter would flag wraps that never happened. It holds port change levels high across several cycles and moves the owner bit while a change is high. A level-sensitive design would set the port flag again after a clear, and one without owner gating would react to ports the companion controller owns. It also fires a completion on the same edge as a clear of the same bit, and writes zeros to a set register. A design that let the clear win would drop the event, and one that treated writes as plain stores would wipe flags.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int unsigned NUM_FLAGS = 4;
  localparam int unsigned FLG_CMPL  = 0;
  localparam int unsigned FLG_ERR   = 1;
  localparam int unsigned FLG_PORT  = 2;
  localparam int unsigned FLG_WRAP  = 3;

  localparam logic ADDR_STS = 1'b0;
  localparam logic ADDR_EN  = 1'b1;

  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/usb_irq_wrap_det.sv
module usb_irq_wrap_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wrap_bit_i,
  output logic wrap_o
);
  logic bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bit_q <= 1'b0;
    else         bit_q <= wrap_bit_i;
  end

  // either direction of the index MSB marks a wrap
  assign wrap_o = wrap_bit_i ^ bit_q;
endmodule

// File: rtl/usb_irq_port_det.sv
module usb_irq_port_det #(
  parameter int unsigned NUM_PORTS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PORTS-1:0] chg_i,
  input  logic [NUM_PORTS-1:0] resume_i,
  input  logic [NUM_PORTS-1:0] owner_i,
  output logic                 evt_o
);
  logic [NUM_PORTS-1:0] hit;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic chg_q, res_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chg_q <= 1'b0;
        res_q <= 1'b0;
      end else begin
        chg_q <= chg_i[p];
        res_q <= resume_i[p];
      end
    end

    // companion-owned ports are masked
    assign hit[p] = ~owner_i[p] & ((chg_i[p] & ~chg_q) | (resume_i[p] & ~res_q));
  end

  assign evt_o = |hit;
endmodule

// File: rtl/usb_irq_xfer_dec.sv
module usb_irq_xfer_dec (
  input  logic vld_i,
  input  logic err_i,
  input  logic ioc_i,
  input  logic short_i,
  output logic set_err_o,
  output logic set_cmpl_o
);
  assign set_err_o  = vld_i & err_i;
  assign set_cmpl_o = vld_i & (ioc_i | short_i);
endmodule

// File: rtl/usb_irq_regs.sv
module usb_irq_regs
  import usb_irq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  flag_vec_t set_i,
  input  logic      we_i,
  input  logic      addr_i,
  input  flag_vec_t wdata_i,
  output flag_vec_t sts_o,
  output flag_vec_t en_o,
  output flag_vec_t rdata_o,
  output logic      irq_o
);
  flag_vec_t sts_q, en_q, clr;

  assign clr = (we_i && addr_i == ADDR_STS) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= (sts_q & ~clr) | set_i;  // set beats clear
      if (we_i && addr_i == ADDR_EN) en_q <= wdata_i;
    end
  end

  assign sts_o   = sts_q;
  assign en_o    = en_q;
  assign rdata_o = (addr_i == ADDR_STS) ? sts_q : en_q;
  assign irq_o   = |(sts_q & en_q);
endmodule

// File: rtl/usb_irq_status.sv
module usb_irq_status
  import usb_irq_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 frnum_wrap_i,
  input  logic [NUM_PORTS-1:0] port_chg_i,
  input  logic [NUM_PORTS-1:0] port_resume_i,
  input  logic [NUM_PORTS-1:0] port_owner_i,
  input  logic                 cmpl_vld_i,
  input  logic                 cmpl_err_i,
  input  logic                 cmpl_ioc_i,
  input  logic                 cmpl_short_i,
  input  logic                 bus_we_i,
  input  logic                 bus_addr_i,
  input  logic [NUM_FLAGS-1:0] bus_wdata_i,
  output logic [NUM_FLAGS-1:0] bus_rdata_o,
  output logic                 irq_o
);
  logic      wrap_evt, port_evt, err_evt, cmpl_evt;
  flag_vec_t set_vec, sts, en;

  usb_irq_wrap_det u_wrap (
    .clk_i, .rst_ni,
    .wrap_bit_i (frnum_wrap_i),
    .wrap_o     (wrap_evt)
  );

  usb_irq_port_det #(.NUM_PORTS(NUM_PORTS)) u_port (
    .clk_i, .rst_ni,
    .chg_i    (port_chg_i),
    .resume_i (port_resume_i),
    .owner_i  (port_owner_i),
    .evt_o    (port_evt)
  );

  usb_irq_xfer_dec u_xfer (
    .vld_i      (cmpl_vld_i),
    .err_i      (cmpl_err_i),
    .ioc_i      (cmpl_ioc_i),
    .short_i    (cmpl_short_i),
    .set_err_o  (err_evt),
    .set_cmpl_o (cmpl_evt)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[FLG_WRAP] = wrap_evt;
    set_vec[FLG_PORT] = port_evt;
    set_vec[FLG_ERR]  = err_evt;
    set_vec[FLG_CMPL] = cmpl_evt;
  end

  usb_irq_regs u_regs (
    .clk_i, .rst_ni,
    .set_i   (set_vec),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .sts_o   (sts),
    .en_o    (en),
    .rdata_o (bus_rdata_o),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/usb_irq_status_chk.sv
module usb_irq_status_chk
  import usb_irq_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 frnum_wrap_i,
  input logic [NUM_PORTS-1:0] port_chg_i,
  input logic [NUM_PORTS-1:0] port_resume_i,
  input logic [NUM_PORTS-1:0] port_owner_i,
  input logic                 cmpl_vld_i,
  input logic                 cmpl_err_i,
  input logic                 cmpl_ioc_i,
  input logic                 bus_we_i,
  input logic                 bus_addr_i,
  input flag_vec_t            bus_wdata_i,
  input flag_vec_t            set_vec,
  input flag_vec_t            sts,
  input logic                 irq_o
);
  logic                 wrap_q;
  logic [NUM_PORTS-1:0] chg_q, res_q;
  logic                 own_rise;
  flag_vec_t            clr_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wrap_q <= 1'b0;
      chg_q  <= '0;
      res_q  <= '0;
    end else begin
      wrap_q <= frnum_wrap_i;
      chg_q  <= port_chg_i;
      res_q  <= port_resume_i;
    end
  end

  assign own_rise = |(~port_owner_i & ((port_chg_i & ~chg_q) | (port_resume_i & ~res_q)));
  assign clr_mask = (bus_we_i && bus_addr_i == ADDR_STS) ? bus_wdata_i : '0;

  // R2
  w1c_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(sts) & ~sts) & ~$past(clr_mask)) == '0);

  // R3
  wrap_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frnum_wrap_i != wrap_q) |=> sts[FLG_WRAP]);

  // R5
  port_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts[FLG_PORT]) |-> $past(own_rise));

  // R8
  err_ioc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_vld_i && cmpl_err_i && cmpl_ioc_i) |=> (sts[FLG_ERR] && sts[FLG_CMPL]));

  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_vec != '0) |=> ((sts & $past(set_vec)) == $past(set_vec)));

  // R10
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !bus_we_i) |=> irq_o);
endmodule

bind usb_irq_status usb_irq_status_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .frnum_wrap_i  (frnum_wrap_i),
  .port_chg_i    (port_chg_i),
  .port_resume_i (port_resume_i),
  .port_owner_i  (port_owner_i),
  .cmpl_vld_i    (cmpl_vld_i),
  .cmpl_err_i    (cmpl_err_i),
  .cmpl_ioc_i    (cmpl_ioc_i),
  .bus_we_i      (bus_we_i),
  .bus_addr_i    (bus_addr_i),
  .bus_wdata_i   (bus_wdata_i),
  .set_vec       (set_vec),
  .sts           (sts),
  .irq_o         (irq_o)
);

// File: tb/sim_usb_irq_status.sv
`timescale 1ns/1ps
module sim_usb_irq_status;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frnum_wrap = 1'b0;
  logic [NP-1:0] chg = '0, res = '0, own = '0;
  logic          vld = 1'b0, err = 1'b0, ioc = 1'b0, shrt = 1'b0;
  logic          we = 1'b0, addr = 1'b0;
  logic [3:0]    wdata = '0;
  logic [3:0]    rdata;
  logic          irq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  usb_irq_status #(.NUM_PORTS(NP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .frnum_wrap_i(frnum_wrap),
    .port_chg_i(chg), .port_resume_i(res), .port_owner_i(own),
    .cmpl_vld_i(vld), .cmpl_err_i(err), .cmpl_ioc_i(ioc), .cmpl_short_i(shrt),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic a, output logic [3:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wr(input logic a, input logic [3:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0; wdata = '0;
  endtask

  task automatic t_reset();
    logic [3:0] d;
    rd(1'b0, d); chk("R1 status", int'(d), 0);
    rd(1'b1, d); chk("R1 enable", int'(d), 0);
    chk("R1 irq", int'(irq), 0);
  endtask

  task automatic t_wrap();
    logic [3:0] d;
    frnum_wrap = 1'b1; tick();
    rd(1'b0, d); chk("R3 rising wrap", int'(d), 4'h8);
    wr(1'b0, 4'h7);
    rd(1'b0, d); chk("R2 write zero keeps", int'(d), 4'h8);
    wr(1'b0, 4'h8);
    rd(1'b0, d); chk("R2 write one clears", int'(d), 4'h0);
    tick();
    rd(1'b0, d); chk("R3 steady bit no wrap", int'(d), 4'h0);
    frnum_wrap = 1'b0; tick();
    rd(1'b0, d); chk("R3 falling wrap", int'(d), 4'h8);
    wr(1'b0, 4'hF);
  endtask

  task automatic t_port();
    logic [3:0] d;
    chg[1] = 1'b1; tick();
    rd(1'b0, d); chk("R4 change edge", int'(d), 4'h4);
    wr(1'b0, 4'h4); tick();
    rd(1'b0, d); chk("R4 held level no reset", int'(d), 4'h0);
    chg[1] = 1'b0;
    res[2] = 1'b1; tick();
    rd(1'b0, d); chk("R4 resume edge", int'(d), 4'h4);
    wr(1'b0, 4'h4);
    res[2] = 1'b0;
    own[3] = 1'b1; tick();
    chg[3] = 1'b1; tick();
    res[3] = 1'b1; tick();
    rd(1'b0, d); chk("R5 owned port masked", int'(d), 4'h0);
    own[3] = 1'b0; tick();
    rd(1'b0, d); chk("R5 owner release no edge", int'(d), 4'h0);
    chg[3] = 1'b0; res[3] = 1'b0; tick();
  endtask

  task automatic t_xfer();
    logic [3:0] d;
    vld = 1'b1; err = 1'b1; tick(); vld = 1'b0; err = 1'b0;
    rd(1'b0, d); chk("R6 error only", int'(d), 4'h2);
    wr(1'b0, 4'hF);
    vld = 1'b1; ioc = 1'b1; tick(); vld = 1'b0; ioc = 1'b0;
    rd(1'b0, d); chk("R7 ioc", int'(d), 4'h1);
    wr(1'b0, 4'hF);
    vld = 1'b1; shrt = 1'b1; tick(); vld = 1'b0; shrt = 1'b0;
    rd(1'b0, d); chk("R7 short packet", int'(d), 4'h1);
    wr(1'b0, 4'hF);
    ioc = 1'b1; tick(); ioc = 1'b0;
    rd(1'b0, d); chk("R7 no valid no set", int'(d), 4'h0);
    vld = 1'b1; err = 1'b1; ioc = 1'b1; tick();
    vld = 1'b0; err = 1'b0; ioc = 1'b0;
    rd(1'b0, d); chk("R8 error with ioc", int'(d), 4'h3);
    wr(1'b0, 4'hF);
  endtask

  task automatic t_set_wins();
    logic [3:0] d;
    vld = 1'b1; ioc = 1'b1; tick(); vld = 1'b0; ioc = 1'b0;
    vld = 1'b1; err = 1'b1;
    we = 1'b1; addr = 1'b0; wdata = 4'h3;
    tick();
    we = 1'b0; wdata = '0; vld = 1'b0; err = 1'b0;
    rd(1'b0, d); chk("R9 set beats clear", int'(d), 4'h2);
    wr(1'b0, 4'hF);
    rd(1'b0, d); chk("R9 cleared after", int'(d), 4'h0);
  endtask

  task automatic t_irq();
    logic [3:0] d;
    vld = 1'b1; err = 1'b1; tick(); vld = 1'b0; err = 1'b0;
    chk("R10 disabled no irq", int'(irq), 0);
    wr(1'b1, 4'h2);
    rd(1'b1, d); chk("R10 enable readback", int'(d), 4'h2);
    chk("R10 enabled irq", int'(irq), 1);
    tick(); tick();
    chk("R10 irq held", int'(irq), 1);
    wr(1'b1, 4'h4);
    chk("R10 other enable no irq", int'(irq), 0);
    chg[0] = 1'b1; tick(); chg[0] = 1'b0;
    chk("R10 port event irq", int'(irq), 1);
    wr(1'b0, 4'h4);
    chk("R10 clear drops irq", int'(irq), 0);
    rd(1'b0, d); chk("R10 error bit untouched", int'(d), 4'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_wrap();
    t_port();
    t_xfer();
    t_set_wins();
    t_irq();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule